// File: doc/BRIEF.md
# Sparse On-Demand Page Memory

This block answers a request/response bus over a wide address space while holding only a small pool of physical pages. An address is split into a page number (address divided by the page size) and an offset inside the page. A fully associative page table tracks which page numbers currently own a physical slot. Reads of pages that own no slot return zero. The first write of a non-zero value to a page claims the lowest free slot. This only happens while a byte budget still has room. The slot is cleared to zero word by word, and then the triggering write is applied. Writes to unmapped pages that do not qualify are dropped.

Accesses are 1, 2, 4 or 8 bytes wide, naturally aligned and little-endian, so no access crosses a page boundary. Each request is accepted with a valid/ready handshake. A read returns its data one cycle after acceptance. Ready is withdrawn while a newly claimed slot is being cleared. A test environment uses the block as a catch-all memory: it can absorb arbitrary traffic while backing only the pages that ever hold data.

Top module: `sparse_mem`

## Requirements
- R1: Bytes written to a mapped page are read back at the same page number and offset, and pages with different page numbers never share storage.
- R2: A read of a page that owns no slot returns all zeros and claims no slot.
- R3: A write to an unmapped page claims a slot only if all of the following hold: its size-selected bytes are non-zero, a slot is free, and used bytes plus one page size is strictly less than MAX_BYTES.
- R4: A newly claimed page reads as zero in every byte the triggering write did not cover, even when its slot held data before a reset.
- R5: A write to an unmapped page that does not qualify under R3 changes nothing: later reads of that page return zero, and the slot and budget stay available.
- R6: Each claim adds exactly one page size to the used-byte count, and the count never reaches MAX_BYTES. With PAGE_BYTES=64 and MAX_BYTES=320, exactly four pages can be claimed.
- R7: req_size codes 0, 1, 2 and 3 select 1, 2, 4 and 8 bytes. Byte i of the access lives at address+i and in bits [8i+7:8i] of the data. Read data is zero-extended above the access size, and addresses are aligned to the size.
- R8: An accepted read raises rsp_valid for exactly the next cycle, carrying its data. An accepted write raises no response.
- R9: After accepting a claiming write, req_ready stays low for PAGE_BYTES/8+1 cycles. Any other accepted request leaves req_ready high.
- R10: Synchronous active-low reset unmaps every page and clears the used-byte count. After reset, req_ready is high and rsp_valid is low.
- R11: A write to a mapped page stores its bytes even when they are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_addr | input | ADDR_W | Byte address, aligned to the access size |
| req_we | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size code: 0=1, 1=2, 2=4, 3=8 bytes |
| req_wdata | input | 64 | Write data, little-endian in the low bytes |
| rsp_valid | output | 1 | Read data valid, one cycle after an accepted read |
| rsp_rdata | output | 64 | Read data, zero-extended |

## Verification
A read's data and rsp_valid are registered, so they are sampled at the falling edge that follows the accepting rising edge. The same sample point confirms that writes raise no response. A hit write is visible to any read accepted on a later edge. A claiming write holds req_ready low for PAGE_BYTES/8+1 cycles. The bench counts these cycles one falling edge at a time and waits for ready to return before issuing the next request, so every later read is compared against a byte-level model only once the clear and the write have completed.

// File: rtl/spm_pkg.sv
// Package: shared state type and size decoding for the sparse page memory.
// Assumes a 64-bit data path with size codes 0..3 meaning 1, 2, 4, 8 bytes.
package spm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CLEAR = 2'd1,
        ST_APPLY = 2'd2
    } spm_state_e;

    // Byte-lane mask of an access of the given size code, lane 0 aligned.
    function automatic logic [7:0] size_lanes(input logic [1:0] sz);
        logic [7:0] m;
        case (sz)
            2'd0:    m = 8'h01;
            2'd1:    m = 8'h03;
            2'd2:    m = 8'h0F;
            default: m = 8'hFF;
        endcase
        return m;
    endfunction

    // Bit mask of an access of the given size code, bit 0 aligned.
    function automatic logic [63:0] size_bits(input logic [1:0] sz);
        logic [63:0] m;
        case (sz)
            2'd0:    m = 64'h0000_0000_0000_00FF;
            2'd1:    m = 64'h0000_0000_0000_FFFF;
            2'd2:    m = 64'h0000_0000_FFFF_FFFF;
            default: m = 64'hFFFF_FFFF_FFFF_FFFF;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/spm_page_table.sv
// Page table: a fully associative set of slots, each holding a valid bit and a
// page-number tag. It reports a hit and the hit slot for one lookup tag, and the
// lowest free slot. A claim writes the tag and sets the valid bit of one slot.
// Assumes the caller never claims an occupied slot or a tag that already hits.
module spm_page_table #(
    parameter int NUM_SLOTS = 8,
    parameter int TAG_W     = 20,
    parameter int SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TAG_W-1:0]  lk_tag,
    output logic              lk_hit,
    output logic [SLOT_W-1:0] lk_slot,
    output logic              free_any,
    output logic [SLOT_W-1:0] free_slot,
    input  logic              claim_en,
    input  logic [SLOT_W-1:0] claim_slot,
    input  logic [TAG_W-1:0]  claim_tag
);
    logic [NUM_SLOTS-1:0] valid_q;
    logic [TAG_W-1:0]     tag_q [NUM_SLOTS];
    logic [NUM_SLOTS-1:0] match;

    // One comparator per slot.
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_cmp
        assign match[g] = valid_q[g] && (tag_q[g] == lk_tag);
    end

    // Encode the matching slot (at most one matches).
    always_comb begin
        lk_slot = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (match[i]) lk_slot = SLOT_W'(i);
        end
    end
    assign lk_hit = |match;

    // Pick the lowest-numbered free slot.
    always_comb begin
        free_slot = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (!valid_q[i]) free_slot = SLOT_W'(i);
        end
    end
    assign free_any = ~&valid_q;

    // Valid bits: cleared by reset, set by a claim.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (claim_en) begin
            valid_q[claim_slot] <= 1'b1;
        end
    end

    // Tags: written on a claim, meaningless while the slot is invalid.
    always_ff @(posedge clk) begin
        if (claim_en) tag_q[claim_slot] <= claim_tag;
    end
endmodule

// File: rtl/spm_budget.sv
// Budget tracker: counts bytes of backing storage handed out and tells whether
// one more page still fits under the strict limit used + page < max.
// Assumes PAGE_BYTES <= MAX_BYTES.
module spm_budget #(
    parameter int PAGE_BYTES = 4096,
    parameter int MAX_BYTES  = 10 * 1024 * 1024,
    parameter int USED_W     = $clog2(MAX_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    output logic [USED_W-1:0] used,
    output logic              room
);
    localparam logic [USED_W:0] PAGE_C = (USED_W + 1)'(PAGE_BYTES);
    localparam logic [USED_W:0] MAX_C  = (USED_W + 1)'(MAX_BYTES);

    logic [USED_W:0] next_total;

    // Budget test for one more page, one bit wider to avoid wrap.
    assign next_total = {1'b0, used} + PAGE_C;
    assign room       = next_total < MAX_C;

    // Used-byte counter: cleared by reset, one page per claim.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            used <= '0;
        end else if (take) begin
            used <= next_total[USED_W-1:0];
        end
    end
endmodule

// File: rtl/spm_store.sv
// Backing store: WORDS 64-bit words split into eight byte lanes with per-lane
// write enables. The read is combinational so that the caller can register it.
// No reset: contents are defined by the caller's clear sequence.
module spm_store #(
    parameter int WORDS = 64,
    parameter int IDX_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_be,
    input  logic [63:0]      wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [63:0]      rd_data
);
    for (genvar b = 0; b < 8; b++) begin : g_lane
        logic [7:0] lane_mem [WORDS];

        // Byte-lane write.
        always_ff @(posedge clk) begin
            if (wr_en && wr_be[b]) lane_mem[wr_idx] <= wr_data[8*b +: 8];
        end

        assign rd_data[8*b +: 8] = lane_mem[rd_idx];
    end
endmodule

// File: rtl/sparse_mem.sv
// Sparse on-demand page memory. It decodes page number, word and byte lane from
// the address, looks the page up in the page table, and serves hits from the
// backing store. A qualifying non-zero write to an unmapped page claims the
// lowest free slot, clears it over PAGE_BYTES/8 cycles, then applies the write.
// Assumes aligned accesses and PAGE_BYTES a power of two of at least 16.
module sparse_mem #(
    parameter int ADDR_W     = 32,
    parameter int PAGE_BYTES = 4096,
    parameter int NUM_SLOTS  = 4,
    parameter int MAX_BYTES  = 10 * 1024 * 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_we,
    input  logic [1:0]        req_size,
    input  logic [63:0]       req_wdata,
    output logic              rsp_valid,
    output logic [63:0]       rsp_rdata
);
    import spm_pkg::*;

    localparam int PAGE_SHIFT = $clog2(PAGE_BYTES);
    localparam int TAG_W      = ADDR_W - PAGE_SHIFT;
    localparam int WPP        = PAGE_BYTES / 8;
    localparam int WORD_W     = PAGE_SHIFT - 3;
    localparam int SLOT_W     = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
    localparam int IDX_W      = SLOT_W + WORD_W;
    localparam int WORDS      = NUM_SLOTS * WPP;
    localparam int USED_W     = $clog2(MAX_BYTES + 1);

    spm_state_e state_q;

    // Address fields.
    logic [TAG_W-1:0]  req_tag;
    logic [WORD_W-1:0] req_word;
    logic [2:0]        req_lane;
    assign req_tag  = req_addr[ADDR_W-1:PAGE_SHIFT];
    assign req_word = req_addr[PAGE_SHIFT-1:3];
    assign req_lane = req_addr[2:0];

    // Lane-aligned write data and byte enables.
    logic [63:0] wdata_sized;
    logic [63:0] wdata_lane;
    logic [7:0]  be_lane;
    logic        wdata_nonzero;
    assign wdata_sized   = req_wdata & size_bits(req_size);
    assign wdata_lane    = wdata_sized << {req_lane, 3'b000};
    assign be_lane       = size_lanes(req_size) << req_lane;
    assign wdata_nonzero = |wdata_sized;

    // Page table.
    logic              lk_hit;
    logic [SLOT_W-1:0] lk_slot;
    logic              free_any;
    logic [SLOT_W-1:0] free_slot;
    logic              claim_go;

    spm_page_table #(
        .NUM_SLOTS (NUM_SLOTS),
        .TAG_W     (TAG_W),
        .SLOT_W    (SLOT_W)
    ) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_tag     (req_tag),
        .lk_hit     (lk_hit),
        .lk_slot    (lk_slot),
        .free_any   (free_any),
        .free_slot  (free_slot),
        .claim_en   (claim_go),
        .claim_slot (free_slot),
        .claim_tag  (req_tag)
    );

    // Budget.
    logic [USED_W-1:0] used_bytes;
    logic              budget_room;

    spm_budget #(
        .PAGE_BYTES (PAGE_BYTES),
        .MAX_BYTES  (MAX_BYTES),
        .USED_W     (USED_W)
    ) u_budget (
        .clk   (clk),
        .rst_n (rst_n),
        .take  (claim_go),
        .used  (used_bytes),
        .room  (budget_room)
    );

    // Request classification.
    logic accept;
    logic rd_go;
    logic wr_hit;
    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign rd_go     = accept && !req_we;
    assign wr_hit    = accept && req_we && lk_hit;
    assign claim_go  = accept && req_we && !lk_hit && wdata_nonzero
                       && budget_room && free_any;

    // Pending write held across the clear sequence.
    logic [SLOT_W-1:0] pend_slot;
    logic [WORD_W-1:0] pend_word;
    logic [7:0]        pend_be;
    logic [63:0]       pend_data;
    logic [WORD_W-1:0] clr_cnt;

    // Latch the claiming write so it can be applied after the clear.
    always_ff @(posedge clk) begin
        if (claim_go) begin
            pend_slot <= free_slot;
            pend_word <= req_word;
            pend_be   <= be_lane;
            pend_data <= wdata_lane;
        end
    end

    // Sequencer: idle, clear the claimed slot word by word, apply the write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            clr_cnt <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    clr_cnt <= '0;
                    if (claim_go) state_q <= ST_CLEAR;
                end
                ST_CLEAR: begin
                    if (clr_cnt == WORD_W'(WPP - 1)) begin
                        state_q <= ST_APPLY;
                    end else begin
                        clr_cnt <= clr_cnt + 1'b1;
                    end
                end
                ST_APPLY: state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    // Store write port: hit write, clear word, or pending write.
    logic             st_wr_en;
    logic [IDX_W-1:0] st_wr_idx;
    logic [7:0]       st_wr_be;
    logic [63:0]      st_wr_data;

    always_comb begin
        st_wr_en   = 1'b0;
        st_wr_idx  = {lk_slot, req_word};
        st_wr_be   = be_lane;
        st_wr_data = wdata_lane;
        case (state_q)
            ST_IDLE:  st_wr_en = wr_hit;
            ST_CLEAR: begin
                st_wr_en   = 1'b1;
                st_wr_idx  = {pend_slot, clr_cnt};
                st_wr_be   = 8'hFF;
                st_wr_data = '0;
            end
            ST_APPLY: begin
                st_wr_en   = 1'b1;
                st_wr_idx  = {pend_slot, pend_word};
                st_wr_be   = pend_be;
                st_wr_data = pend_data;
            end
            default:  st_wr_en = 1'b0;
        endcase
    end

    logic [63:0] st_rd_data;

    spm_store #(
        .WORDS (WORDS),
        .IDX_W (IDX_W)
    ) u_store (
        .clk     (clk),
        .wr_en   (st_wr_en),
        .wr_idx  (st_wr_idx),
        .wr_be   (st_wr_be),
        .wr_data (st_wr_data),
        .rd_idx  ({lk_slot, req_word}),
        .rd_data (st_rd_data)
    );

    // Read response: one cycle after acceptance, zero on a miss.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= rd_go;
            if (rd_go) begin
                rsp_rdata <= lk_hit
                    ? ((st_rd_data >> {req_lane, 3'b000}) & size_bits(req_size))
                    : 64'd0;
            end
        end
    end
endmodule

// File: rtl/sparse_mem_chk.sv
// Checker for the sparse page memory: handshake timing, miss data, budget
// growth and alignment. Attached to every sparse_mem instance by bind.
module sparse_mem_chk #(
    parameter int ADDR_W     = 32,
    parameter int PAGE_BYTES = 4096,
    parameter int MAX_BYTES  = 10 * 1024 * 1024,
    parameter int USED_W     = $clog2(MAX_BYTES + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_we,
    input logic [ADDR_W-1:0] req_addr,
    input logic [1:0]        req_size,
    input logic              rsp_valid,
    input logic [63:0]       rsp_rdata,
    input logic              lk_hit,
    input logic [USED_W-1:0] used_bytes
);
    logic [2:0] align_mask;
    assign align_mask = 3'((4'd1 << req_size) - 4'd1);

    AST_READ_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_we) |=> rsp_valid); // R8
    AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_we) |=> !rsp_valid); // R8
    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_we && !lk_hit) |=> (rsp_rdata == 64'd0)); // R2
    AST_PAGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(used_bytes) |-> (used_bytes == $past(used_bytes) + USED_W'(PAGE_BYTES))); // R6
    AST_UNDER_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        used_bytes < USED_W'(MAX_BYTES)); // R6
    AST_STALL_ON_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_ready) |-> (used_bytes == $past(used_bytes) + USED_W'(PAGE_BYTES))); // R9
    AST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |-> ((req_addr[2:0] & align_mask) == 3'd0)); // R7
endmodule

bind sparse_mem sparse_mem_chk #(
    .ADDR_W     (ADDR_W),
    .PAGE_BYTES (PAGE_BYTES),
    .MAX_BYTES  (MAX_BYTES),
    .USED_W     (USED_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_we     (req_we),
    .req_addr   (req_addr),
    .req_size   (req_size),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .lk_hit     (lk_hit),
    .used_bytes (used_bytes)
);

// File: tb/tb_sparse_mem.sv
`timescale 1ns/1ps
// Bench: 8 slots of 64-byte pages, budget 320 bytes (four pages). A byte-level
// model of 16 candidate pages gives every expected value.
module tb_sparse_mem;
    localparam int AW    = 16;
    localparam int PB    = 64;
    localparam int NS    = 8;
    localparam int MAXB  = 320;
    localparam int NPG   = 16;
    localparam int STALL = PB / 8 + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic          req_we = 1'b0;
    logic [1:0]    req_size = 2'd0;
    logic [63:0]   req_wdata = '0;
    logic          rsp_valid;
    logic [63:0]   rsp_rdata;

    always #2.5 clk = ~clk;

    sparse_mem #(.ADDR_W(AW), .PAGE_BYTES(PB), .NUM_SLOTS(NS), .MAX_BYTES(MAXB)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_we(req_we), .req_size(req_size),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata));

    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    logic [7:0] mdl [NPG][PB];
    bit   mapped [NPG];
    int   used = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] addr_of(input int k, input int off);
        return AW'((k * 37 + 3) * PB + off);
    endfunction

    function automatic logic [63:0] pat(input int k, input int off, input int salt);
        return {8{8'(k * 29 + off * 7 + salt * 13 + 1)}} ^ 64'h9E37_79B9_7F4A_7C15;
    endfunction

    // Model write; returns 1 when the write claims a page.
    function automatic bit mdl_write(input int k, input int off, input logic [1:0] sz,
                                     input logic [63:0] d);
        int n = 1 << sz;
        logic [63:0] m = (sz == 2'd3) ? '1 : ((64'd1 << (8 * n)) - 1);
        bit claimed = 1'b0;
        if (!mapped[k]) begin
            if ((d & m) != 0 && used + PB < MAXB) begin
                mapped[k] = 1'b1;
                used += PB;
                claimed = 1'b1;
                for (int i = 0; i < PB; i++) mdl[k][i] = 8'h00;
            end else begin
                return 1'b0;
            end
        end
        for (int i = 0; i < n; i++) mdl[k][off + i] = d[8*i +: 8];
        return claimed;
    endfunction

    function automatic logic [63:0] mdl_read(input int k, input int off, input logic [1:0] sz);
        logic [63:0] v = '0;
        if (mapped[k]) begin
            for (int i = 0; i < (1 << sz); i++) v[8*i +: 8] = mdl[k][off + i];
        end
        return v;
    endfunction

    // Bus write; checks no response and the ready-low cycle count.
    task automatic wr(input int k, input int off, input logic [1:0] sz,
                      input logic [63:0] d, input string req);
        int  low = 0;
        bit  rv;
        bit  claimed;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_we = 1'b1; req_addr = addr_of(k, off);
        req_size = sz; req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_we = 1'b0;
        rv = rsp_valid;
        while (!req_ready) begin
            low++;
            @(negedge clk);
        end
        claimed = mdl_write(k, off, sz, d);
        chk(!rv, "R8 write raised rsp_valid", 64'(rv), 64'd0);
        chk(low == (claimed ? STALL : 0), {req, " / R9 ready-low cycles"},
            64'(low), 64'(claimed ? STALL : 0));
    endtask

    // Bus read; checks the response strobe and the data against the model.
    task automatic rd(input int k, input int off, input logic [1:0] sz, input string req);
        logic [63:0] exp;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_we = 1'b0; req_addr = addr_of(k, off); req_size = sz;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        exp = mdl_read(k, off, sz);
        chk(rsp_valid, "R8 read response strobe", 64'(rsp_valid), 64'd1);
        chk(rsp_rdata == exp, req, rsp_rdata, exp);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < NPG; k++) mapped[k] = 1'b0;
        used = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < NPG; k++) mapped[k] = 1'b0;
        do_reset();
        @(negedge clk);
        chk(req_ready, "R10 ready after reset", 64'(req_ready), 64'd1);
        chk(!rsp_valid, "R10 rsp_valid after reset", 64'(rsp_valid), 64'd0);
        @(negedge clk);
        chk(!rsp_valid, "R8 rsp_valid idle", 64'(rsp_valid), 64'd0);

        // R2: every candidate page reads zero before any write.
        for (int k = 0; k < NPG; k++) begin
            rd(k, 0, 2'd3, "R2 unmapped read");
            rd(k, PB - 8, 2'd3, "R2 unmapped read");
        end

        // R5: zero writes, including zero after size masking, are dropped.
        wr(0, 0, 2'd3, 64'd0, "R5 zero write dropped");
        wr(1, 4, 2'd0, 64'hFFFF_FF00, "R5 masked-zero write dropped");
        rd(0, 0, 2'd3, "R5 page stays unmapped");
        rd(1, 0, 2'd3, "R5 page stays unmapped");

        // R3/R4: first non-zero byte claims page 0; rest of page is zero.
        wr(0, 5, 2'd0, 64'hA5, "R3 claiming write");
        for (int w = 0; w < PB / 8; w++) rd(0, w * 8, 2'd3, "R4 fresh page zero-filled");

        // R7: byte writes across the page, then reads of every size and offset.
        for (int o = 0; o < PB; o++) wr(0, o, 2'd0, pat(0, o, 1), "R7 byte write");
        for (int s = 0; s < 4; s++) begin
            for (int o = 0; o < PB; o += (1 << s)) rd(0, o, 2'(s), "R7 sized read");
        end
        for (int s = 1; s < 4; s++) begin
            for (int o = 0; o < PB; o += 2 * (1 << s)) wr(0, o, 2'(s), pat(0, o, s + 2), "R7 sized write");
            for (int w = 0; w < PB / 8; w++) rd(0, w * 8, 2'd3, "R7 little-endian merge");
        end

        // R11: zero write to a mapped page stores zeros.
        wr(0, 16, 2'd3, 64'd0, "R11 zero write to mapped page");
        rd(0, 16, 2'd3, "R11 zero stored");
        rd(0, 16, 2'd1, "R11 zero stored");

        // R1/R6: three more pages fit, the fifth is refused by the budget.
        for (int k = 1; k < 4; k++) wr(k, 8 * k, 2'd3, pat(k, 0, 9), "R6 claim within budget");
        wr(4, 0, 2'd3, pat(4, 0, 9), "R6 claim over budget refused");
        rd(4, 0, 2'd3, "R5 over-budget page reads zero");
        for (int k = 0; k < 5; k++) begin
            for (int w = 0; w < PB / 8; w++) rd(k, w * 8, 2'd3, "R1 distinct pages");
        end

        // R10/R4: reset unmaps all; a reused slot is cleared again.
        do_reset();
        for (int k = 0; k < 4; k++) rd(k, 8, 2'd3, "R10 unmapped after reset");
        wr(5, 8, 2'd3, pat(5, 8, 3), "R3 claim after reset");
        for (int w = 0; w < PB / 8; w++) rd(5, w * 8, 2'd3, "R4 reused slot zero-filled");
        for (int k = 6; k < 10; k++) wr(k, 0, 2'd2, pat(k, 0, 4), "R6 budget restored by reset");
        for (int k = 5; k < 10; k++) rd(k, 0, 2'd3, "R6 four pages after reset");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule